// File: doc/BRIEF.md
# Pipelined Phase Accumulator

This block is the phase accumulator of a direct digital frequency synthesizer. On every clock edge it adds a frequency-control word to a running phase value. The phase wraps modulo 2^W. The resulting phase word is meant to address a sine lookup further down the chain. A constant increment K gives an output frequency of K·fclk/2^W, so the frequency step is fclk/2^W. The usable tuning range reaches up to roughly a third of the clock rate.

To keep the critical path down to a two-bit add, the accumulator is cut into W/2 slices of two bits each. Each slice adds its share of the increment into its own two-bit register, together with a carry that the slice below registered on the previous cycle. Because every carry hop costs one cycle, slice k is fed increment bits that are held back k cycles more than those of slice 0. Slice k's sum is then held for W/2−1−k more cycles, so every bit of the output word belongs to the same accumulation. The cost is a fixed latency of W/2 clock edges. In return the clock rate no longer depends on the word width.

The block has no control states. It is a fixed pipeline whose only mode change is the synchronous reset, which clears every stage.

Top module: `dds_phase_acc`

## Requirements
- R1: While `rst` is high at a rising edge, every accumulator, carry and delay stage is cleared, so `phase_o` reads 0 after that edge. It stays 0 until a nonzero increment reaches the output.
- R2: After each edge e, `phase_o` equals the modulo-2^W sum of all `inc_i` values sampled at edges from the last reset up to and including edge e−W/2.
- R3: An increment sampled at edge t leaves `phase_o` unchanged through edge t+W/2−1. It first appears at the output after edge t+W/2.
- R4: The carry out of the top slice is dropped, so the phase wraps modulo 2^W (for W=8: 0xFF plus 0x01 reads 0x00).
- R5: Carries that cross one or more slice boundaries land in the same output word as the sum bits they belong to. No output word ever shows a partly carried value.
- R6: While the increment is 0, `phase_o` holds its value, once the nonzero words sampled earlier have drained.
- R7: Increments that change on every edge are each counted exactly once, in the order they were sampled.
- R8: A reset in the middle of a run discards every increment sampled before or during the reset. None of them reaches the output afterwards.
- R9: A constant increment K advances `phase_o` by exactly K on every edge once the pipeline is full. With K = 2^(W−1), the top output bit toggles on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | PHASE_W | Phase increment (frequency-control word), sampled every edge |
| phase_o | output | PHASE_W | Aligned phase word, W/2 edges behind the increments it includes |

## Verification
The checker keeps its own history of sampled increments. On every edge it checks that the step between consecutive phase words equals the increment sampled exactly W/2 edges earlier. That one check covers accumulation, latency, wraparound and carry alignment. It also checks on every edge that the output is zero after each reset edge and that the output holds while the delayed increment is zero. Only the bench scenarios can show the interactions over whole sequences. These are the exact drain point after a single pulse, a mid-run reset that throws away in-flight words, the ripple of a carry through all slices, and the top-bit toggle under a half-range step.

// File: rtl/dds_acc_pkg.sv
package dds_acc_pkg;

    // Bits handled by one adder slice; the carry between slices is registered.
    localparam int unsigned SLICE_W = 2;

    function automatic logic xor3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

endpackage

// File: rtl/dds_delay_line.sv
module dds_delay_line #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/dds_acc_slice.sv
module dds_acc_slice
    import dds_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SLICE_W-1:0] inc_bits,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o
);

    logic [SLICE_W-1:0] acc_q;
    logic [SLICE_W-1:0] acc_next;
    logic [SLICE_W:0]   chain;
    logic               cout_q;

    assign chain[0] = cin_i;

    // Ripple inside the slice: operand A is the increment, B is the slice's own sum.
    for (genvar b = 0; b < SLICE_W; b++) begin : g_bit
        assign acc_next[b]  = xor3(inc_bits[b], acc_q[b], chain[b]);
        assign chain[b+1]   = maj3(inc_bits[b], acc_q[b], chain[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            acc_q  <= acc_next;
            cout_q <= chain[SLICE_W];
        end
    end

    assign sum_o  = acc_q;
    assign cout_o = cout_q;

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_acc_pkg::*;
#(
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] inc_i,
    output logic [PHASE_W-1:0] phase_o
);

    localparam int unsigned NSLICE = PHASE_W / SLICE_W;

    // carry_q[k] is the registered carry entering slice k.
    logic [NSLICE-1:0] carry_q;
    logic              carry_top_unused;

    assign carry_q[0] = 1'b0;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        logic [SLICE_W-1:0] inc_skew;
        logic [SLICE_W-1:0] sum_k;

        // Input skew: one input register plus k cycles per slice position.
        dds_delay_line #(
            .WIDTH (SLICE_W),
            .DEPTH (k + 1)
        ) u_skew (
            .clk  (clk),
            .rst  (rst),
            .din  (inc_i[k*SLICE_W +: SLICE_W]),
            .dout (inc_skew)
        );

        if (k < NSLICE - 1) begin : g_mid
            dds_acc_slice u_add (
                .clk      (clk),
                .rst      (rst),
                .inc_bits (inc_skew),
                .cin_i    (carry_q[k]),
                .sum_o    (sum_k),
                .cout_o   (carry_q[k+1])
            );

            // Output deskew: lower slices wait for the top slice to catch up.
            dds_delay_line #(
                .WIDTH (SLICE_W),
                .DEPTH (NSLICE - 1 - k)
            ) u_deskew (
                .clk  (clk),
                .rst  (rst),
                .din  (sum_k),
                .dout (phase_o[k*SLICE_W +: SLICE_W])
            );
        end else begin : g_top
            dds_acc_slice u_add (
                .clk      (clk),
                .rst      (rst),
                .inc_bits (inc_skew),
                .cin_i    (carry_q[k]),
                .sum_o    (sum_k),
                .cout_o   (carry_top_unused)
            );

            assign phase_o[k*SLICE_W +: SLICE_W] = sum_k;
        end
    end

endmodule

// File: rtl/dds_phase_acc_chk.sv
module dds_phase_acc_chk
    import dds_acc_pkg::*;
#(
    parameter int unsigned PHASE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] inc_i,
    input logic [PHASE_W-1:0] phase_o
);

    localparam int unsigned NSLICE = PHASE_W / SLICE_W;

    // hist[j] holds the increment sampled j+1 edges before the current one.
    logic [PHASE_W-1:0] hist [NSLICE+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= NSLICE; i++) hist[i] <= '0;
        end else begin
            hist[0] <= inc_i;
            for (int i = 1; i <= NSLICE; i++) hist[i] <= hist[i-1];
        end
    end

    // R1: a reset edge leaves a zero phase word.
    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> phase_o == '0);

    // R2, also R3/R4/R5/R7: each step equals the increment from exactly NSLICE edges back.
    p_accum_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase_o - $past(phase_o)) == hist[NSLICE]);

    // R6: a zero increment reaching the output leaves the phase unchanged.
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hist[NSLICE] == '0) |-> $stable(phase_o));

    // R8: the cycle after reset releases still shows zero, nothing leaked through.
    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> phase_o == '0);

endmodule

bind dds_phase_acc dds_phase_acc_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (inc_i),
    .phase_o (phase_o)
);

// File: tb/test_dds_phase_acc.sv
module test_dds_phase_acc;

    localparam int unsigned PW         = 8;
    localparam int unsigned NS         = PW / 2;
    localparam time         CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] inc_i = '0;
    logic [PW-1:0] phase_o;

    int n_cmp = 0;
    int n_bad = 0;

    dds_phase_acc #(.PHASE_W(PW)) i_dds_phase_acc (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (inc_i),
        .phase_o (phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: plain single-cycle accumulator followed by an NS-deep delay.
    logic [PW-1:0] ref_acc;
    logic [PW-1:0] ref_dly [NS];

    always @(posedge clk) begin
        if (rst) begin
            ref_acc <= '0;
            for (int i = 0; i < NS; i++) ref_dly[i] <= '0;
        end else begin
            ref_acc    <= ref_acc + inc_i;
            ref_dly[0] <= ref_acc;
            for (int i = 1; i < NS; i++) ref_dly[i] <= ref_dly[i-1];
        end
    end

    task automatic chk(input string req, input logic [PW-1:0] exp);
        n_cmp++;
        if (phase_o !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_o=%h expected=%h at %0t", req, phase_o, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic tick(input logic [PW-1:0] v);
        inc_i = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick('0);
        tick('0);
        tick('0);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset state", '0);
        for (int j = 0; j < 5; j++) begin
            tick('0);
            chk("R1 idle after reset", '0);
        end
    endtask

    task automatic t_latency();
        do_reset();
        tick(8'h05);
        chk("R3 pulse not yet visible", '0);
        for (int j = 1; j < NS; j++) begin
            tick('0);
            chk("R3 pulse not yet visible", '0);
        end
        tick('0);
        chk("R3 pulse appears after W/2 edges", 8'h05);
        tick('0);
        chk("R6 pulse result held", 8'h05);
    endtask

    task automatic t_constant_step(input logic [PW-1:0] k, input string req);
        do_reset();
        for (int j = 0; j < 3 * NS + 4; j++) begin
            logic [PW-1:0] exp;
            tick(k);
            exp = (j < NS) ? '0 : PW'((j - NS + 1) * k);
            chk(req, exp);
            chk("R2 reference", ref_dly[NS-1]);
        end
    endtask

    task automatic t_carry_wrap();
        do_reset();
        tick(8'hFF);
        tick(8'h01);
        tick(8'h55);
        tick(8'hAB);
        tick(8'h03);
        tick(8'h01);
        for (int j = 0; j < NS + 2; j++) begin
            tick('0);
            chk("R5 carry across slices", ref_dly[NS-1]);
        end
        // 0xFF+0x01+0x55+0xAB+0x03+0x01 = 0x204 -> 0x04 mod 256
        chk("R4 wrap modulo 2^W", 8'h04);
    endtask

    task automatic t_hold();
        do_reset();
        tick(8'h21);
        tick(8'h21);
        tick(8'h21);
        for (int j = 0; j < 12; j++) begin
            tick('0);
            if (j >= NS - 1) chk("R6 hold under zero increment", 8'h63);
            else             chk("R6 drain", ref_dly[NS-1]);
        end
    endtask

    task automatic t_varying();
        logic [PW-1:0] v = 8'h3C;
        do_reset();
        for (int j = 0; j < 40; j++) begin
            v = v * 8'd37 + 8'd11;
            tick(v);
            chk("R7 changing increments", ref_dly[NS-1]);
        end
        for (int j = 0; j < NS; j++) begin
            tick('0);
            chk("R7 tail", ref_dly[NS-1]);
        end
    endtask

    task automatic t_mid_reset();
        do_reset();
        for (int j = 0; j < 6; j++) tick(8'h35);
        rst = 1'b1;
        tick(8'h77);
        tick(8'h77);
        rst = 1'b0;
        for (int j = 0; j < NS + 3; j++) begin
            tick('0);
            chk("R8 flushed by mid-run reset", '0);
        end
        tick(8'h02);
        for (int j = 0; j < NS; j++) tick('0);
        chk("R8 fresh accumulation after reset", 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): run did not complete, actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_latency();
        t_constant_step(8'h03, "R9 constant step 3");
        t_constant_step(8'h80, "R9 half-range step toggles top bit");
        t_carry_wrap();
        t_hold();
        t_varying();
        t_mid_reset();
        summary();
        $finish;
    end

endmodule